// File: doc/BRIEF.md
# SPI Phase-Zero Shift Engine

This block moves one byte at a time over a four-wire serial link. It can act as the clock-owning master or as a selected slave, and it always uses clock phase zero. Data is sampled on the first clock edge of each bit, which is the edge leaving the idle level. Data is shifted on the second edge, the one returning to the idle level. A single byte-wide shifter serves both roles. A control input picks the bit order, and another picks the idle level of the serial clock.

As master, a one-cycle start pulse loads the transmit byte and begins a transfer. The serial clock comes from an internal half-period counter. As slave, the falling edge of the low-true select loads the transmit byte and puts its first bit on the data output at once, before any clock edge arrives. The select must rise again between bytes. In both roles a completion pulse lasting one system clock marks the arrival of a full received byte.

Top module: `spi_cp0_engine`

## Requirements
- R1: In slave mode (`master`=0), within 4 system clocks after `ss_n_in` falls, `sdo_en` is 1 and `sdo` shows the first transmit bit, with no serial clock edge needed.
- R2: `lsb_first`=1 selects bit 0 of the byte as the first bit sent and received. `lsb_first`=0 selects bit 7 first.
- R3: The leading serial clock edge (leaving the `cpol` level) samples the data input. The trailing edge moves the shifter and presents the next transmit bit on `sdo`.
- R4: In master mode the serial clock rests at `cpol` while idle. After a start it toggles 16 times, once every `clk_div` system clocks (values below 2 act as 2), and `busy` is high from the start until the 16th toggle.
- R5: `done` is a one-system-clock pulse raised with the 8th sampling edge. `rx_byte` takes the received byte in that same cycle and holds its value at all other times.
- R6: In slave mode, if `ss_n_in` rises before the 8th sample, the partial byte is dropped with no `done` pulse and `rx_byte` unchanged. The next fall of `ss_n_in` reloads the transmit byte from its first bit.
- R7: In slave mode, once a byte completes, further serial clock edges are ignored until `ss_n_in` goes high and then low again. No `done` pulse occurs, and `sdo` and `rx_byte` stay unchanged.
- R8: In master mode, `tx_start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master | input | 1 | 1 = master role, 0 = slave role |
| lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| cpol | input | 1 | Idle level of the serial clock |
| clk_div | input | DIV_W | System clocks per serial clock half-period (minimum 2) |
| tx_byte | input | DATA_W | Byte to transmit |
| tx_start | input | 1 | Master start pulse |
| sclk_in | input | 1 | Serial clock from an external master |
| ss_n_in | input | 1 | Low-true slave select |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | High while `sdo` should be driven |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | DATA_W | Last completed received byte |

## Verification
A miscounted half-period or edge shows up at `sclk_out` within one divider period, because the master clock and `busy` are compared against the model on every system clock. A wrong bit index or a wrong shift direction changes `sdo` in the bit window where it happens, and it corrupts `rx_byte` when `done` pulses. In slave mode, a bad select-edge detector appears either as a wrong first bit a few clocks after select falls, or as a missing or extra `done` pulse after an aborted byte or after surplus clock edges.

// File: rtl/spi_cp0_pkg.sv
package spi_cp0_pkg;
  typedef enum logic {ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1} role_e;

  // Index of the sync vector lanes
  localparam int LANE_SDI  = 0;
  localparam int LANE_SS   = 1;
  localparam int LANE_SCLK = 2;
  localparam int LANES     = 3;
endpackage

// File: rtl/spi_cp0_sync.sv
module spi_cp0_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= RST_VAL[i];
        q[i]      <= RST_VAL[i];
      end else begin
        stage1[i] <= d[i];
        q[i]      <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/spi_cp0_clkgen.sv
module spi_cp0_clkgen #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             lead,
  output logic             trail,
  output logic             running
);
  localparam int NTOG = 2 * DATA_W;
  localparam int TW   = $clog2(NTOG + 1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic [TW-1:0]    tog;
  logic             hit;

  assign div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
  assign hit     = running && (cnt == div_eff - DIV_W'(1));
  assign lead    = hit && !tog[0];
  assign trail   = hit && tog[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      tog     <= '0;
      sclk    <= cpol;
    end else if (!running) begin
      sclk <= cpol;
      cnt  <= '0;
      tog  <= '0;
      if (start) running <= 1'b1;
    end else if (hit) begin
      cnt  <= '0;
      sclk <= ~sclk;
      tog  <= tog + TW'(1);
      if (tog == TW'(NTOG - 1)) running <= 1'b0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_cp0_shifter.sv
module spi_cp0_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              abort,
  input  logic              lead,
  input  logic              trail,
  input  logic              din,
  input  logic              lsb_first,
  output logic              sdo,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              samp;

  assign sdo = lsb_first ? sh[0] : sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= '0;
      active  <= 1'b0;
      done    <= 1'b0;
      samp    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh     <= load_data;
        cnt    <= '0;
        active <= 1'b1;
      end else if (abort) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        if (lead && cnt < CW'(DATA_W)) begin
          samp <= din;
          cnt  <= cnt + CW'(1);
          if (cnt == CW'(DATA_W - 1)) begin
            done    <= 1'b1;
            rx_data <= lsb_first ? {din, sh[DATA_W-1:1]} : {sh[DATA_W-2:0], din};
          end
        end else if (trail && cnt != '0) begin
          sh <= lsb_first ? {samp, sh[DATA_W-1:1]} : {sh[DATA_W-2:0], samp};
          if (cnt == CW'(DATA_W)) active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cp0_engine.sv
module spi_cp0_engine
  import spi_cp0_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic              lsb_first,
  input  logic              cpol,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_start,
  input  logic              sclk_in,
  input  logic              ss_n_in,
  input  logic              sdi,
  output logic              sclk_out,
  output logic              sdo,
  output logic              sdo_en,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  logic [LANES-1:0] pins_raw, pins_s;
  logic s_sclk, s_ss, s_sdi;
  logic sclk_q, ss_q;
  logic is_master;

  assign is_master = (role_e'(master) == ROLE_MASTER);

  assign pins_raw[LANE_SDI]  = sdi;
  assign pins_raw[LANE_SS]   = ss_n_in;
  assign pins_raw[LANE_SCLK] = sclk_in;

  spi_cp0_sync #(.W(LANES), .RST_VAL(LANES'(1) << LANE_SS)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  assign s_sclk = pins_s[LANE_SCLK];
  assign s_ss   = pins_s[LANE_SS];
  assign s_sdi  = pins_s[LANE_SDI];

  // Slave-side edge detection in the system clock domain
  logic ss_fall, ss_rise, sclk_chg, sl_lead, sl_trail;
  assign ss_fall  = !is_master && !s_ss && ss_q;
  assign ss_rise  = !is_master && s_ss && !ss_q;
  assign sclk_chg = s_sclk != sclk_q;
  assign sl_lead  = !is_master && !s_ss && sclk_chg && (s_sclk != cpol);
  assign sl_trail = !is_master && !s_ss && sclk_chg && (s_sclk == cpol);

  logic slave_drive;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q      <= 1'b0;
      ss_q        <= 1'b1;
      slave_drive <= 1'b0;
    end else begin
      sclk_q <= s_sclk;
      ss_q   <= s_ss;
      if (is_master || ss_rise) slave_drive <= 1'b0;
      else if (ss_fall)         slave_drive <= 1'b1;
    end
  end

  // Master clock generation
  logic m_run, m_lead, m_trail, m_start;
  assign m_start = is_master && tx_start && !m_run;

  spi_cp0_clkgen #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_clkgen (
    .clk(clk), .rst(rst), .start(m_start), .cpol(cpol), .div(clk_div),
    .sclk(sclk_out), .lead(m_lead), .trail(m_trail), .running(m_run)
  );

  // Shared shifter
  logic sh_active;
  spi_cp0_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst),
    .load(is_master ? m_start : ss_fall),
    .load_data(tx_byte),
    .abort(ss_rise),
    .lead(is_master ? m_lead : sl_lead),
    .trail(is_master ? m_trail : sl_trail),
    .din(is_master ? sdi : s_sdi),
    .lsb_first(lsb_first),
    .sdo(sdo), .active(sh_active), .done(done), .rx_data(rx_byte)
  );

  assign busy   = is_master ? m_run : sh_active;
  assign sdo_en = is_master ? m_run : slave_drive;
endmodule

// File: rtl/spi_cp0_engine_chk.sv
module spi_cp0_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              master,
  input logic              cpol,
  input logic              tx_start,
  input logic              busy,
  input logic              done,
  input logic              sclk_out,
  input logic [DATA_W-1:0] rx_byte
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_RX_HELD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(rx_byte)); // R5
  AST_DONE_IN_XFER: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy)); // R3
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (master && !busy && !$past(busy) && $stable(cpol)) |-> sclk_out == cpol); // R4
  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (master && tx_start && !busy) |=> busy); // R8
endmodule

bind spi_cp0_engine spi_cp0_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .master(master), .cpol(cpol), .tx_start(tx_start),
  .busy(busy), .done(done), .sclk_out(sclk_out), .rx_byte(rx_byte)
);

// File: tb/spi_cp0_engine_tb.sv
`timescale 1ns/1ps
module spi_cp0_engine_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master = 1'b1, lsb_first = 1'b0, cpol = 1'b0;
  logic [7:0] clk_div = 8'd2;
  logic [7:0] tx_byte = 8'h00;
  logic tx_start = 1'b0, sclk_in = 1'b0, ss_n_in = 1'b1, sdi = 1'b0;
  logic sclk_out, sdo, sdo_en, busy, done;
  logic [7:0] rx_byte;

  int total = 0, bad = 0, dcount = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_cp0_engine #(.DATA_W(8), .DIV_W(8)) dut_i (
    .clk(clk), .rst(rst), .master(master), .lsb_first(lsb_first), .cpol(cpol),
    .clk_div(clk_div), .tx_byte(tx_byte), .tx_start(tx_start), .sclk_in(sclk_in),
    .ss_n_in(ss_n_in), .sdi(sdi), .sclk_out(sclk_out), .sdo(sdo), .sdo_en(sdo_en),
    .busy(busy), .done(done), .rx_byte(rx_byte)
  );

  always @(posedge clk) begin
    if (rst) dcount <= 0;
    else if (done) dcount <= dcount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic bitsel(input logic [7:0] b, input int k, input bit lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  // Reference model of a master transfer, compared on every clock
  task automatic run_master(input logic [7:0] txv, input logic [7:0] rxv,
                            input int div, input bit lsb, input bit pol, input bit poke);
    int de = (div < 2) ? 2 : div;
    int tg, idx;
    logic [7:0] rx0;
    @(negedge clk);
    master = 1'b1; lsb_first = lsb; cpol = pol; clk_div = div[7:0];
    repeat (2) @(negedge clk);
    check(sclk_out === pol && !busy, "R4 idle level", sclk_out, pol);
    rx0 = rx_byte;
    tx_byte = txv; sdi = bitsel(rxv, 0, lsb); tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int t = 0; t < 16 * de + 3; t++) begin
      tg = t / de;
      if (tg > 16) tg = 16;
      check(sclk_out === (pol ^ tg[0]), "R4 sclk", sclk_out, pol ^ tg[0]);
      check(busy === (t < 16 * de), "R4 busy", busy, t < 16 * de);
      check(done === (t == 15 * de), "R5 done", done, t == 15 * de);
      if (t < 16 * de) begin
        idx = t / (2 * de);
        check(sdo === bitsel(txv, idx, lsb) && sdo_en, "R2 R3 master sdo", sdo, bitsel(txv, idx, lsb));
      end
      if (t >= 15 * de) check(rx_byte === rxv, "R3 R2 rx", rx_byte, rxv);
      else              check(rx_byte === rx0, "R5 rx held", rx_byte, rx0);
      idx = (t + 1) / (2 * de);
      if (idx < 8) sdi = bitsel(rxv, idx, lsb);
      if (poke) begin
        tx_start = (t == 3);   // R8: start while busy
        if (t == 3) tx_byte = ~txv;
      end
      @(negedge clk);
    end
    tx_start = 1'b0;
  endtask

  // Behavioural external master driving the slave
  task automatic run_slave(input logic [7:0] txv, input logic [7:0] mv,
                           input bit lsb, input bit pol, input int abort_k, input string tag);
    int base;
    logic [7:0] rx0;
    @(negedge clk);
    master = 1'b0; lsb_first = lsb; cpol = pol; sclk_in = pol; ss_n_in = 1'b1; tx_byte = txv;
    repeat (6) @(negedge clk);
    base = dcount; rx0 = rx_byte;
    ss_n_in = 1'b0; sdi = bitsel(mv, 0, lsb);
    repeat (5) @(negedge clk);
    check(sdo === bitsel(txv, 0, lsb) && sdo_en === 1'b1, {"R1 first bit ", tag}, sdo, bitsel(txv, 0, lsb));
    for (int k = 0; k < 8; k++) begin
      sdi = bitsel(mv, k, lsb);
      repeat (8) @(negedge clk);
      sclk_in = ~pol;
      repeat (8) @(negedge clk);
      if (k == abort_k) begin
        ss_n_in = 1'b1; sclk_in = pol;
        break;
      end
      sclk_in = pol;
      repeat (5) @(negedge clk);
      if (k < 7) check(sdo === bitsel(txv, k + 1, lsb), "R3 R2 slave sdo", sdo, bitsel(txv, k + 1, lsb));
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    if (abort_k < 8) begin
      check(dcount - base == 0, "R6 no done on abort", dcount - base, 0);
      check(rx_byte === rx0, "R6 rx kept", rx_byte, rx0);
    end else begin
      check(dcount - base == 1, "R5 one done", dcount - base, 1);
      check(rx_byte === mv, "R5 R3 slave rx", rx_byte, mv);
    end
  endtask

  task automatic extra_clocks(input bit pol);
    int base;
    logic [7:0] rx0;
    logic s0;
    base = dcount; rx0 = rx_byte; s0 = sdo;
    for (int k = 0; k < 8; k++) begin
      sdi = ~sdi;
      repeat (8) @(negedge clk); sclk_in = ~pol;
      repeat (8) @(negedge clk); sclk_in = pol;
    end
    repeat (8) @(negedge clk);
    check(dcount - base == 0, "R7 no done", dcount - base, 0);
    check(rx_byte === rx0, "R7 rx unchanged", rx_byte, rx0);
    check(sdo === s0, "R7 sdo unchanged", sdo, s0);
    ss_n_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !sdo_en, "R4 reset idle", busy, 0);
    check(sclk_out === 1'b0 && rx_byte === 8'h00, "R5 reset rx", rx_byte, 0);

    run_master(8'hA5, 8'h3C, 2, 1'b0, 1'b0, 1'b0);
    run_master(8'h1E, 8'hC9, 3, 1'b1, 1'b1, 1'b1);
    run_master(8'h6B, 8'h92, 1, 1'b0, 1'b0, 1'b0);

    run_slave(8'hC3, 8'h5A, 1'b0, 1'b0, 8, "msb");
    ss_n_in = 1'b1; repeat (6) @(negedge clk);
    run_slave(8'h2D, 8'hB4, 1'b1, 1'b1, 8, "lsb");
    ss_n_in = 1'b1; repeat (6) @(negedge clk);
    run_slave(8'h81, 8'h7E, 1'b0, 1'b0, 3, "pre-abort");
    run_slave(8'h4F, 8'hE2, 1'b0, 1'b0, 8, "R6 reload");
    extra_clocks(1'b0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule